// File: doc/BRIEF.md
# Multi-Die Status Output Selector

This block decides which die on a shared flash target may drive the byte-wide bus, and what it drives. It sees command-latch and address-latch strobes that have already been decoded, together with the bus byte, chip-enable and read-enable. It also receives the 8-bit status register of every die. From these it keeps a selected die index and a mode flag (status or array data). It produces one output enable per die, the output byte and a ready/busy level.

Command 70h switches to status output for the die that was selected last. Command 78h starts a selection. The die index is then taken from the top bits of the third row-address byte that follows, and every other die is deselected. Any other command that a ready die accepts leaves status mode, so the enabled die drives array data. Command 00h is the usual case. While a selection is in progress no die is enabled, which keeps two dies from driving the bus at the same time.

Top module: `die_status_sel`

## Requirements
- R1: After reset the block is in array-data mode. Die 0 is selected, no selection is pending, and the output byte is 00h.
- R2: A command strobe carrying 70h sets status mode and keeps the currently selected die.
- R3: A command strobe carrying 78h sets status mode and starts a selection. On the third address strobe after it, bits [7:6] of the bus byte become the selected die. Until then, all die output enables are low.
- R4: When the selected die is ready, a command strobe carrying any code other than 70h or 78h clears status mode. With 00h this means array-data mode: the output byte is 00h and the selected die stays enabled.
- R5: In status mode the output byte is the selected die's status register, bit for bit. This includes bit 5, which is 0 while a program operation is in progress. The byte follows changes in that register in the same cycle, without any read-enable toggle.
- R6: rdy_o equals bit 6 of the selected die's status register.
- R7: The output enable of the selected die is high only while both ce_ni and re_ni are low. At most one enable is ever high.
- R8: While the selected die is busy (status bit 6 = 0), command strobes other than 70h and 78h have no effect. 70h and 78h are still accepted.
- R9: Address strobes outside a 78h selection have no effect. A command strobe that arrives during a selection ends the selection. A command strobe takes priority over an address strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_stb_i | input | 1 | One-cycle command-latch strobe |
| addr_stb_i | input | 1 | One-cycle address-latch strobe |
| io_i | input | 8 | Command or address byte on the bus |
| ce_ni | input | 1 | Chip enable, active low |
| re_ni | input | 1 | Read enable, active low |
| die_status_i | input | N_DIE*8 | Status registers; die k in bits [8k+7:8k] |
| die_oe_o | output | N_DIE | Per-die output enable |
| status_mode_o | output | 1 | 1 = status output, 0 = array data |
| dout_o | output | 8 | Status byte in status mode, else 00h |
| rdy_o | output | 1 | Ready/busy, follows status bit 6 of the selected die |

## Verification
The assertions take for granted that the strobes are single-cycle pulses, and that the host never starts a new address strobe in the same cycle as a command. Where both do occur, R9 gives the command priority. The stimulus drives every strobe for exactly one clock, away from the sampling edge. Status bytes change only between strobes, so the same-cycle following of R5 is observed on a stable selection. Busy dies are produced by clearing status bit 6 in the bench's own status vector.

// File: rtl/die_status_pkg.sv
package die_status_pkg;
  localparam logic [7:0] CMD_STAT     = 8'h70;
  localparam logic [7:0] CMD_STAT_SEL = 8'h78;
  localparam logic [7:0] CMD_ARRAY    = 8'h00;
  localparam int unsigned STAT_W      = 8;
  localparam int unsigned RDY_BIT     = 6;

  typedef enum logic {MODE_ARRAY = 1'b0, MODE_STATUS = 1'b1} out_mode_e;
endpackage

// File: rtl/die_sel_ctrl.sv
module die_sel_ctrl
  import die_status_pkg::*;
#(
  parameter int unsigned N_DIE   = 4,
  parameter int unsigned ROW_CYC = 3,
  localparam int unsigned DIE_W  = $clog2(N_DIE),
  localparam int unsigned CNT_W  = $clog2(ROW_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_stb_i,
  input  logic             addr_stb_i,
  input  logic [7:0]       io_i,
  input  logic             rdy_i,
  output logic [DIE_W-1:0] sel_o,
  output out_mode_e        mode_o,
  output logic             pend_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ROW_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             is_stat, is_sel;

  assign is_stat = (io_i == CMD_STAT);
  assign is_sel  = (io_i == CMD_STAT_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= '0;
      mode_o <= MODE_ARRAY;
      pend_o <= 1'b0;
      cnt_q  <= '0;
    end else if (cmd_stb_i) begin
      if (is_stat) begin
        mode_o <= MODE_STATUS;
        pend_o <= 1'b0;
        cnt_q  <= '0;
      end else if (is_sel) begin
        mode_o <= MODE_STATUS;
        pend_o <= 1'b1;
        cnt_q  <= '0;
      end else if (rdy_i) begin
        // busy die ignores everything except the status commands
        mode_o <= MODE_ARRAY;
        pend_o <= 1'b0;
        cnt_q  <= '0;
      end
    end else if (addr_stb_i && pend_o) begin
      if (cnt_q == LAST) begin
        sel_o  <= io_i[7 -: DIE_W];
        pend_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  stat_keeps_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i && is_stat |=> $stable(sel_o) && mode_o == MODE_STATUS && !pend_o);

  // R4
  array_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i && io_i == CMD_ARRAY && rdy_i |=> mode_o == MODE_ARRAY);

  // R8
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stb_i && !is_stat && !is_sel && !rdy_i
    |=> $stable(mode_o) && $stable(sel_o) && $stable(pend_o));

  // R9
  stray_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_i && !cmd_stb_i && !pend_o |=> $stable(sel_o) && $stable(mode_o) && !pend_o);

  // R3
  sel_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_i && !cmd_stb_i && pend_o && cnt_q == LAST
    |=> !pend_o && sel_o == $past(io_i[7 -: DIE_W]));
endmodule

// File: rtl/die_oe_gen.sv
module die_oe_gen #(
  parameter int unsigned N_DIE  = 4,
  localparam int unsigned DIE_W = $clog2(N_DIE)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIE_W-1:0] sel_i,
  output logic [N_DIE-1:0] oe_o
);
  for (genvar i = 0; i < N_DIE; i++) begin : g_oe
    assign oe_o[i] = en_i && (sel_i == DIE_W'(i));
  end

  // R7
  oe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(oe_o));
endmodule

// File: rtl/die_stat_mux.sv
module die_stat_mux
  import die_status_pkg::*;
#(
  parameter int unsigned N_DIE  = 4,
  localparam int unsigned DIE_W = $clog2(N_DIE)
) (
  input  logic [N_DIE*STAT_W-1:0] stat_i,
  input  logic [DIE_W-1:0]        sel_i,
  input  out_mode_e               mode_i,
  output logic [STAT_W-1:0]       dout_o,
  output logic                    rdy_o
);
  logic [STAT_W-1:0] cur;

  assign cur    = stat_i[sel_i*STAT_W +: STAT_W];
  assign rdy_o  = cur[RDY_BIT];
  assign dout_o = (mode_i == MODE_STATUS) ? cur : '0;
endmodule

// File: rtl/die_status_sel.sv
module die_status_sel
  import die_status_pkg::*;
#(
  parameter int unsigned N_DIE   = 4,
  parameter int unsigned ROW_CYC = 3,
  localparam int unsigned DIE_W  = $clog2(N_DIE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_stb_i,
  input  logic                    addr_stb_i,
  input  logic [7:0]              io_i,
  input  logic                    ce_ni,
  input  logic                    re_ni,
  input  logic [N_DIE*STAT_W-1:0] die_status_i,
  output logic [N_DIE-1:0]        die_oe_o,
  output logic                    status_mode_o,
  output logic [STAT_W-1:0]       dout_o,
  output logic                    rdy_o
);
  logic [DIE_W-1:0] sel;
  out_mode_e        mode;
  logic             pend;
  logic             oe_en;

  die_sel_ctrl #(.N_DIE(N_DIE), .ROW_CYC(ROW_CYC)) u_ctrl (
    .clk_i, .rst_ni, .cmd_stb_i, .addr_stb_i, .io_i,
    .rdy_i(rdy_o), .sel_o(sel), .mode_o(mode), .pend_o(pend)
  );

  assign oe_en = !ce_ni && !re_ni && !pend;

  die_oe_gen #(.N_DIE(N_DIE)) u_oe (
    .clk_i, .rst_ni, .en_i(oe_en), .sel_i(sel), .oe_o(die_oe_o)
  );

  die_stat_mux #(.N_DIE(N_DIE)) u_mux (
    .stat_i(die_status_i), .sel_i(sel), .mode_i(mode),
    .dout_o, .rdy_o
  );

  assign status_mode_o = (mode == MODE_STATUS);

  // R7
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || re_ni) |-> die_oe_o == '0);

  // R3
  pend_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend |-> die_oe_o == '0);
endmodule

// File: tb/sim_die_status_sel.sv
module sim_die_status_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0, addr_stb = 1'b0;
  logic [7:0]  io = '0;
  logic        ce_n = 1'b1, re_n = 1'b1;
  logic [31:0] stat = 32'hE3E2E1E0;
  logic [3:0]  oe;
  logic        smode, rdy;
  logic [7:0]  dout;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  die_status_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_stb_i(cmd_stb), .addr_stb_i(addr_stb),
    .io_i(io), .ce_ni(ce_n), .re_ni(re_n), .die_status_i(stat),
    .die_oe_o(oe), .status_mode_o(smode), .dout_o(dout), .rdy_o(rdy)
  );

  // {typ(0 cmd,1 addr), byte, exp oe, exp dout}
  localparam logic [21:0] VEC [18] = '{
    {2'd0, 8'h70, 4'b0001, 8'hE0},  // R2
    {2'd0, 8'h78, 4'b0000, 8'hE0},  // R3
    {2'd1, 8'h00, 4'b0000, 8'hE0},
    {2'd1, 8'h00, 4'b0000, 8'hE0},
    {2'd1, 8'h80, 4'b0100, 8'hE2},  // R3 die 2
    {2'd0, 8'h70, 4'b0100, 8'hE2},  // R2
    {2'd0, 8'h00, 4'b0100, 8'h00},  // R4
    {2'd1, 8'hC0, 4'b0100, 8'h00},  // R9
    {2'd0, 8'h78, 4'b0000, 8'hE2},
    {2'd1, 8'h11, 4'b0000, 8'hE2},
    {2'd1, 8'h22, 4'b0000, 8'hE2},
    {2'd1, 8'hC5, 4'b1000, 8'hE3},  // R3 die 3
    {2'd0, 8'h00, 4'b1000, 8'h00},  // R4
    {2'd0, 8'h78, 4'b0000, 8'hE3},
    {2'd1, 8'hFF, 4'b0000, 8'hE3},
    {2'd1, 8'hFF, 4'b0000, 8'hE3},
    {2'd1, 8'h40, 4'b0010, 8'hE1},  // R3 die 1
    {2'd0, 8'h90, 4'b0010, 8'h00}   // R4 other code
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic is_addr, input logic [7:0] b);
    @(negedge clk);
    cmd_stb  = !is_addr;
    addr_stb = is_addr;
    io       = b;
    @(negedge clk);
    cmd_stb  = 1'b0;
    addr_stb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    re_n = 1'b0;
    #1;
    check("R1 oe", 32'(oe), 32'b0001);
    check("R1 mode", 32'(smode), 0);
    check("R1 dout", 32'(dout), 0);
    check("R6 rdy", 32'(rdy), 1);

    for (int i = 0; i < 18; i++) begin
      step(VEC[i][20], VEC[i][19:12]);
      check($sformatf("R3/R4 vec %0d oe", i), 32'(oe), 32'(VEC[i][11:8]));
      check($sformatf("R5 vec %0d dout", i), 32'(dout), 32'(VEC[i][7:0]));
    end

    // R7 gating by ce/re
    ce_n = 1'b1; #1;
    check("R7 ce high", 32'(oe), 0);
    ce_n = 1'b0; re_n = 1'b1; #1;
    check("R7 re high", 32'(oe), 0);
    re_n = 1'b0; #1;
    check("R7 both low", 32'(oe), 32'b0010);

    // R5 live follow, bit 5 low during program
    step(1'b0, 8'h70);
    stat[15:8] = 8'hC1; #1;
    check("R5 live bit5", 32'(dout), 32'hC1);

    // R6/R8 busy die
    stat[15:8] = 8'h81; #1;
    check("R6 busy rdy", 32'(rdy), 0);
    step(1'b0, 8'h00);
    check("R8 00h ignored", 32'(smode), 1);
    check("R8 00h ignored dout", 32'(dout), 32'h81);
    step(1'b0, 8'h78);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    step(1'b1, 8'h3F);
    check("R8 78h while busy oe", 32'(oe), 32'b0001);
    check("R8 78h while busy dout", 32'(dout), 32'hE0);

    // R9 command aborts selection
    step(1'b0, 8'h78);
    step(1'b1, 8'hC0);
    step(1'b0, 8'h70);
    check("R9 abort oe", 32'(oe), 32'b0001);
    step(1'b1, 8'hC0);
    step(1'b1, 8'hC0);
    check("R9 stray addr", 32'(oe), 32'b0001);

    // R9 command wins over simultaneous address
    step(1'b0, 8'h78);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    @(negedge clk);
    cmd_stb = 1'b1; addr_stb = 1'b1; io = 8'h70;
    @(negedge clk);
    cmd_stb = 1'b0; addr_stb = 1'b0;
    check("R9 priority oe", 32'(oe), 32'b0001);
    check("R9 priority dout", 32'(dout), 32'hE0);

    // R1 reset mid-run
    step(1'b0, 8'h78);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    step(1'b1, 8'hC0);
    rst_n = 1'b0; #1;
    check("R1 reset oe", 32'(oe), 32'b0001);
    check("R1 reset dout", 32'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;

    finish_run();
  end
endmodule